// File: doc/BRIEF.md
# Run-Length Variant Sequencer

This block drives the argument selection of a streaming process. Each firing of the process uses one variant. A variant fixes which of two sources feeds the first input, which of two sources feeds the second input, and which of three outputs are written to their queues. An output that is not enabled is still computed by the process, but it is dropped and not written. All argument choices are folded into one variant identifier, so a single down-counter is enough to follow the schedule. The design does not keep one predicate or one counter per argument.

A schedule table is written through a load port before the run. Each entry holds a variant identifier and a run length. After a start pulse, the block fetches entry 0 and loads the counter with its run length. It then shows that variant's select pattern while it accepts firings. The counter steps down once for each accepted firing. When the count reaches zero, the block fetches the next entry. Firings are held off during the fetch cycle, so every accepted firing carries the select pattern of the variant that owns it. A zero run length ends the schedule. Running past the last table entry also ends it.

Top module: `variant_runlen_seq`

## Requirements
- R1: While reset is held low and right after it is released, `active`, `done` and `fire_ok` are low, and `out_en`, `src_a`, `src_b` and `var_id` are zero.
- R2: A `start` pulse restarts the schedule at entry 0 from any state. The edge that takes `start` is followed by one fetch cycle, and then `active` is high with entry 0's variant.
- R3: While `active` is high, `fire_ok` equals `fire`. An entry stays active for exactly its run length of accepted firings, and cycles without `fire` do not consume any of that count.
- R4: On the edge after the last accepted firing of an entry, the block spends one fetch cycle. In that cycle `active` and `fire_ok` are low even when `fire` is high. The next entry becomes active on the following edge.
- R5: Fetching an entry whose run length is zero raises `done` and leaves `active` low. `done` then holds until the next `start`.
- R6: When all 64 entries have been run and none of them has a zero run length, the next fetch raises `done`.
- R7: While a variant is active, `src_a` selects input A's source (0 = source 1, 1 = source 2). `src_b` selects input B's source (0 = source 3, 1 = source 4). Bit k of `out_en` enables output k+1. The variants map as follows: 1 → A1, B3, outputs {1}; 2 → A2, B3, outputs {1,2}; 3 → A1, B4, outputs {2,3}; 4 → A2, B4, outputs {1,3}; 5 → A1, B3, outputs {1,2,3}; 6 → A2, B4, outputs {2}; 7 → A1, B4, outputs {1}; 8 → A2, B3, outputs {3}; 9 → A1, B3, outputs {3}.
- R8: A variant identifier of 0 or 10–15 still runs for its run length. While it runs, `src_a`, `src_b` and `out_en` are all zero, and `var_id` shows the identifier.
- R9: While `active` is low, `fire_ok`, `src_a`, `src_b`, `out_en` and `var_id` are zero.
- R10: Run lengths use the full 16 bits. An entry of 40000 accepts exactly 40000 firings.
- R11: A `start` taken while an entry is active drops the remaining count. The schedule then runs again from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_we | input | 1 | Write strobe for the schedule table |
| load_addr | input | 6 | Table entry to write |
| load_id | input | 4 | Variant identifier to store |
| load_dist | input | 16 | Run length to store (0 ends the schedule) |
| start | input | 1 | Restart the schedule at entry 0 |
| fire | input | 1 | The process requests a firing |
| fire_ok | output | 1 | Firing accepted in this cycle |
| active | output | 1 | A variant is being presented |
| var_id | output | 4 | Identifier of the active variant |
| src_a | output | 1 | Source choice for input A |
| src_b | output | 1 | Source choice for input B |
| out_en | output | 3 | Write enables for outputs 1 to 3 |
| done | output | 1 | Schedule finished |

## Verification
The embedded properties assume two things. First, the table is written only while no schedule is running. Second, `start` is a one-cycle pulse. Without these, a count or an entry could change under a running variant. The bench writes every table entry while the block is idle or done, and it raises `start` only for one cycle at a time. Firing requests come either as a continuous stream or from a pseudo-random pattern. This places stalls before, during and right after the last firing of each entry.

// File: rtl/variant_runlen_seq.sv
module variant_runlen_seq #(
  parameter int IDW   = 4,
  parameter int DISTW = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [AW-1:0]    load_addr,
  input  logic [IDW-1:0]   load_id,
  input  logic [DISTW-1:0] load_dist,
  input  logic             start,
  input  logic             fire,
  output logic             fire_ok,
  output logic             active,
  output logic [IDW-1:0]   var_id,
  output logic             src_a,
  output logic             src_b,
  output logic [2:0]       out_en,
  output logic             done
);
  localparam logic [AW:0] PEND = (AW+1)'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN, S_DONE} st_t;

  logic [IDW+DISTW-1:0] sched [DEPTH];
  st_t                  state;
  logic [AW:0]          ptr;
  logic [DISTW-1:0]     cnt;
  logic [IDW-1:0]       cur_id;
  logic [IDW-1:0]       ent_id;
  logic [DISTW-1:0]     ent_dist;
  logic [4:0]           pat;
  logic                 last;

  always_ff @(posedge clk)
    if (load_we) sched[load_addr] <= {load_id, load_dist};

  assign {ent_id, ent_dist} = sched[ptr[AW-1:0]];
  assign last = (cnt == DISTW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ptr    <= '0;
      cnt    <= '0;
      cur_id <= '0;
    end else if (start) begin
      state <= S_FETCH;
      ptr   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_FETCH:
          if (ptr == PEND || ent_dist == '0) begin
            state <= S_DONE;
          end else begin
            cnt    <= ent_dist;
            cur_id <= ent_id;
            ptr    <= ptr + 1'b1;
            state  <= S_RUN;
          end
        S_RUN:
          if (fire) begin
            cnt <= cnt - 1'b1;
            if (last) state <= S_FETCH;
          end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cur_id)
      4'd1:    pat = 5'b0_0_001;
      4'd2:    pat = 5'b1_0_011;
      4'd3:    pat = 5'b0_1_110;
      4'd4:    pat = 5'b1_1_101;
      4'd5:    pat = 5'b0_0_111;
      4'd6:    pat = 5'b1_1_010;
      4'd7:    pat = 5'b0_1_001;
      4'd8:    pat = 5'b1_0_100;
      4'd9:    pat = 5'b0_0_100;
      default: pat = 5'b0_0_000;
    endcase
  end

  assign active  = (state == S_RUN);
  assign done    = (state == S_DONE);
  assign fire_ok = active & fire;
  assign var_id  = active ? cur_id : '0;
  assign src_a   = active & pat[4];
  assign src_b   = active & pat[3];
  assign out_en  = active ? pat[2:0] : 3'b000;

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fire && !last && !start) |=> (active && cnt == $past(cnt) - 1'b1 && var_id == $past(var_id)));

  assert_hold_idle_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fire && !start) |=> (active && $stable(cnt)));

  assert_fetch_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fire && last && !start) |=> (!active && !fire_ok));

  assert_live_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt != '0);

  assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!fire_ok && out_en == 3'b000 && !src_a && !src_b));

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!active && !done));
endmodule

// File: tb/tb_variant_runlen_seq.sv
module tb_variant_runlen_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load_we = 0;
  logic [5:0]  load_addr = '0;
  logic [3:0]  load_id = '0;
  logic [15:0] load_dist = '0;
  logic        start = 0;
  logic        fire = 0;
  logic        fire_ok, active, src_a, src_b, done;
  logic [3:0]  var_id;
  logic [2:0]  out_en;

  int vectors = 0, errors = 0, cycles = 0, fired = 0;
  int b_id [64];
  int b_dist [64];
  int m_phase = 0, m_ptr = 0, m_rem = 0, m_id = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  variant_runlen_seq dut (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
    .load_id(load_id), .load_dist(load_dist), .start(start), .fire(fire),
    .fire_ok(fire_ok), .active(active), .var_id(var_id), .src_a(src_a),
    .src_b(src_b), .out_en(out_en), .done(done));

  function automatic logic [4:0] exp_pat(int id);
    case (id)
      1: return 5'b00001;  2: return 5'b10011;  3: return 5'b01110;
      4: return 5'b11101;  5: return 5'b00111;  6: return 5'b11010;
      7: return 5'b01001;  8: return 5'b10100;  9: return 5'b00100;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
        report();
      end
    end
  end

  task automatic check();
    logic       e_act, e_ok, e_done;
    logic [4:0] ep;
    logic [3:0] eid;
    e_act  = (m_phase == 2);
    e_done = (m_phase == 3);
    e_ok   = e_act & fire;
    ep     = e_act ? exp_pat(m_id) : 5'b0;
    eid    = e_act ? 4'(m_id) : 4'd0;
    vectors++;
    if (fire_ok) fired++;
    if (fire_ok !== e_ok || active !== e_act) begin
      errors++;
      $display("FAIL R3,R4: fire_ok/active actual %b%b expected %b%b", fire_ok, active, e_ok, e_act);
    end
    if (done !== e_done) begin
      errors++;
      $display("FAIL R5,R6: done actual %b expected %b", done, e_done);
    end
    if ({src_a, src_b, out_en} !== ep || var_id !== eid) begin
      errors++;
      $display("FAIL R7,R8,R9: sel actual %b id %0d expected %b id %0d",
               {src_a, src_b, out_en}, var_id, ep, eid);
    end
  endtask

  task automatic cyc(input logic f, input logic s);
    fire = f; start = s;
    #1 check();
    @(posedge clk);
    if (s) begin
      m_phase = 1; m_ptr = 0;
    end else if (m_phase == 1) begin
      if (m_ptr == 64 || b_dist[m_ptr] == 0) m_phase = 3;
      else begin
        m_rem = b_dist[m_ptr]; m_id = b_id[m_ptr]; m_ptr++; m_phase = 2;
      end
    end else if (m_phase == 2 && f) begin
      m_rem--;
      if (m_rem == 0) m_phase = 1;
    end
    @(negedge clk);
  endtask

  task automatic load(input int a, input int id, input int d);
    load_we = 1; load_addr = 6'(a); load_id = 4'(id); load_dist = 16'(d);
    b_id[a] = id; b_dist[a] = d;
    @(negedge clk);
    load_we = 0;
  endtask

  task automatic run(input int mode, input int maxc);
    int n = 0;
    cyc(0, 1);
    while (m_phase != 3 && n < maxc) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(mode == 0 ? 1'b1 : (lfsr[0] | lfsr[1]), 0);
      n++;
    end
    for (int k = 0; k < 3; k++) cyc(1, 0);
  endtask

  task automatic expect_fired(input int exp, input string tag);
    vectors++;
    if (fired != exp) begin
      errors++;
      $display("FAIL %s: accepted firings actual %0d expected %0d", tag, fired, exp);
    end
  endtask

  task automatic load_s1();
    for (int i = 0; i < 9; i++) load(i, i + 1, (i % 3) + 1);
    load(9, 0, 2);
    load(10, 13, 1);
    load(11, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin b_id[i] = 0; b_dist[i] = 0; end
    @(negedge clk);
    cyc(1, 0);  // R1 during reset
    cyc(1, 0);
    rst_n = 1;
    cyc(1, 0);  // R1 after release
    // R2 R3 R4 R5 R7 R8: all variants, continuous firing
    load_s1();
    fired = 0; run(0, 1000); expect_fired(21, "R3");
    // R3 R4: same schedule with gapped firing
    fired = 0; run(1, 1000); expect_fired(21, "R3");
    // R6: full table without a terminating entry
    for (int i = 0; i < 64; i++) load(i, (i % 9) + 1, 1 + (i % 2));
    fired = 0; run(1, 2000); expect_fired(96, "R6");
    // R10: long run length
    load(0, 3, 40000);
    load(1, 9, 1);
    load(2, 0, 0);
    fired = 0; run(0, 41000); expect_fired(40001, "R10");
    // R11: restart while active
    load_s1();
    cyc(0, 1);
    for (int k = 0; k < 7; k++) cyc(1, 0);
    fired = 0; run(0, 1000); expect_fired(21, "R11");
    report();
  end
endmodule